// File: doc/BRIEF.md
# Serial-Probe Pseudo-Associative Read Cache

The block is a read cache that gets set-associative placement out of one direct-mapped line array. It has `LINES` storage positions. Logically these are grouped into `LINES/WAYS` sets, and each set has `WAYS` candidate positions. The set number is the lowest bits of the request address. A probe numbered `i` reads the array line whose index has `i` in the upper bits and the set number in the lower bits.

A lookup reads one line per cycle, starting at probe 0 and moving up. It stops at the first probe whose valid bit is set and whose stored tag matches. A request is sent to the next memory level only when every probe has missed. The returned word is then written into the set and also given back to the requester.

Each response carries three things: the data, a hit flag and the number of probes used. That probe count is the latency the request saw. A line holds one data word, so the block address is the same as the request address. The stored tag is every address bit above the set number, so a line may sit in any of its set's positions.

Top module: `serial_pcache`

## Requirements
- R1: After reset, `reqReady` is 1 and `respValid` and `memReqValid` are 0. Every line is invalid, so the first access to any address misses.
- R2: The set number is `reqAddr[SET_W-1:0]`, with SET_W = log2(LINES/WAYS). Probe i reads array line {i, set}. Addresses in different sets never displace each other.
- R3: Probes run in the order 0, 1, …, WAYS-1, one per cycle. A hit on probe p (counted from 1) gives `respHit`=1 and `respProbes`=p, and `respValid` rises p clock edges after the edge that accepted the request.
- R4: When all WAYS probes miss, the block raises exactly one memory request carrying the request address. The response then has `respHit`=0, `respProbes`=WAYS, and `respData` equal to the word the memory returned.
- R5: A request that hits issues no memory request.
- R6: A fill goes to the lowest-numbered probe position in the set that is invalid.
- R7: If every position in the set is valid, the fill replaces the position named by that set's round-robin pointer. The pointer starts at 0 and advances by one (modulo WAYS) only after such a replacement. Each set has its own pointer.
- R8: Only one request is outstanding at a time. After an accepting edge, `reqReady` stays 0 until the response has been given.
- R9: While `memReqValid` is 1 and `memReqReady` is 0, the request stays valid and `memReqAddr` does not change.
- R10: `respValid` is a single-cycle pulse.
- R11: A hit returns the word that was filled for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request valid |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Read address (one word per line) |
| respValid | output | 1 | One-cycle response strobe |
| respData | output | DATA_W | Read data |
| respHit | output | 1 | 1 if served from the array |
| respProbes | output | clog2(WAYS+1) | Probes used (WAYS on a miss) |
| memReqValid | output | 1 | Next-level read request valid |
| memReqReady | input | 1 | Next level accepts the request |
| memReqAddr | output | ADDR_W | Next-level read address |
| memRespValid | input | 1 | Next-level data strobe |
| memRespData | input | DATA_W | Next-level read data |

## Verification
The properties rely on the next level behaving in two ways. It raises `memRespValid` only after it has accepted a request, and it returns exactly one word for each request. They also rely on the requester holding `reqValid` only for cycles in which it wants a transfer. The bench's memory model holds `memReqReady` low for a varying number of cycles before accepting. It answers a fixed number of cycles after acceptance, and only once per accepted request. The requester drives `reqValid` for a single cycle, and only once it has seen `reqReady` high.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

  // Strobes from the sequencer to the datapath, at most one set per cycle
  typedef struct packed {
    logic loadReq;   // capture request address, restart probe index
    logic advance;   // step to the next probe position
    logic takeHit;   // latch response from the probed line
    logic takeFill;  // write memory word into the set and latch response
  } ctrlStrobe_t;

endpackage

// File: rtl/pcache_datapath.sv
module pcache_datapath
  import pcache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int LINES  = 16,
  parameter int WAYS   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [DATA_W-1:0]          memRespData,
  output logic                       probeHit,
  output logic                       lastProbe,
  output logic [ADDR_W-1:0]          blockAddr,
  output logic [DATA_W-1:0]          respData,
  output logic                       respHit,
  output logic [$clog2(WAYS+1)-1:0]  respProbes
);

  localparam int SETS   = LINES / WAYS;
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = WAY_W + SET_W;
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int CNT_W  = $clog2(WAYS+1);

  logic [ADDR_W-1:0] addrQ;
  logic [WAY_W-1:0]  probeIdx;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];
  logic [LINES-1:0]  validArr;
  logic [WAY_W-1:0]  rrPtr   [SETS];

  logic [SET_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagQ;
  logic [LINE_W-1:0] lineIdx;
  logic [WAY_W-1:0]  victimWay;
  logic              foundFree;
  logic [LINE_W-1:0] fillIdx;
  logic [WAY_W-1:0]  rrNext;

  assign setIdx    = addrQ[SET_W-1:0];
  assign tagQ      = addrQ[ADDR_W-1:SET_W];
  assign lineIdx   = {probeIdx, setIdx};
  assign probeHit  = validArr[lineIdx] && (tagArr[lineIdx] == tagQ);
  assign lastProbe = (probeIdx == WAY_W'(WAYS-1));
  assign blockAddr = addrQ;
  assign fillIdx   = {victimWay, setIdx};

  // Victim choice: lowest invalid position in probe order, else round robin
  always_comb begin
    victimWay = rrPtr[setIdx];
    foundFree = 1'b0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!validArr[{WAY_W'(w), setIdx}]) begin
        victimWay = WAY_W'(w);
        foundFree = 1'b1;
      end
    end
  end

  // Pointer wrap that also works for a non-power-of-two way count
  assign rrNext = (rrPtr[setIdx] == WAY_W'(WAYS-1)) ? '0 : rrPtr[setIdx] + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ      <= '0;
      probeIdx   <= '0;
      validArr   <= '0;
      respData   <= '0;
      respHit    <= 1'b0;
      respProbes <= '0;
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrQ    <= reqAddr;
        probeIdx <= '0;
      end
      if (strobe.advance) probeIdx <= probeIdx + 1'b1;
      if (strobe.takeHit) begin
        respData   <= dataArr[lineIdx];
        respHit    <= 1'b1;
        respProbes <= CNT_W'(probeIdx) + 1'b1;
      end
      if (strobe.takeFill) begin
        validArr[fillIdx] <= 1'b1;
        if (!foundFree) rrPtr[setIdx] <= rrNext;
        respData   <= memRespData;
        respHit    <= 1'b0;
        respProbes <= CNT_W'(WAYS);
      end
    end
  end

  // Storage without reset; validity is tracked separately
  always_ff @(posedge clk) begin
    if (strobe.takeFill) begin
      tagArr[fillIdx]  <= tagQ;
      dataArr[fillIdx] <= memRespData;
    end
  end

endmodule

// File: rtl/pcache_control.sv
module pcache_control
  import pcache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        probeHit,
  input  logic        lastProbe,
  input  logic        memReqReady,
  input  logic        memRespValid,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        respValid,
  output logic        memReqValid
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROBE, ST_MEMREQ, ST_MEMWAIT, ST_RESP
  } seqState_t;

  seqState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    respValid   = 1'b0;
    memReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          stateNext      = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (probeHit) begin
          strobe.takeHit = 1'b1;
          stateNext      = ST_RESP;
        end else if (lastProbe) begin
          stateNext = ST_MEMREQ;
        end else begin
          strobe.advance = 1'b1;
        end
      end
      ST_MEMREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_MEMWAIT;
      end
      ST_MEMWAIT: begin
        if (memRespValid) begin
          strobe.takeFill = 1'b1;
          stateNext       = ST_RESP;
        end
      end
      ST_RESP: begin
        respValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/serial_pcache.sv
module serial_pcache
  import pcache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int LINES  = 16,
  parameter int WAYS   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic                      respValid,
  output logic [DATA_W-1:0]         respData,
  output logic                      respHit,
  output logic [$clog2(WAYS+1)-1:0] respProbes,
  output logic                      memReqValid,
  input  logic                      memReqReady,
  output logic [ADDR_W-1:0]         memReqAddr,
  input  logic                      memRespValid,
  input  logic [DATA_W-1:0]         memRespData
);

  ctrlStrobe_t strobe;
  logic        probeHit;
  logic        lastProbe;

  pcache_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .probeHit     (probeHit),
    .lastProbe    (lastProbe),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .strobe       (strobe),
    .reqReady     (reqReady),
    .respValid    (respValid),
    .memReqValid  (memReqValid)
  );

  pcache_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES),
    .WAYS   (WAYS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .memRespData (memRespData),
    .probeHit    (probeHit),
    .lastProbe   (lastProbe),
    .blockAddr   (memReqAddr),
    .respData    (respData),
    .respHit     (respHit),
    .respProbes  (respProbes)
  );

endmodule

// File: rtl/pcache_checker.sv
module pcache_checker #(
  parameter int ADDR_W = 12,
  parameter int WAYS   = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic                      reqReady,
  input logic                      respValid,
  input logic                      respHit,
  input logic [$clog2(WAYS+1)-1:0] respProbes,
  input logic                      memReqValid,
  input logic                      memReqReady,
  input logic [ADDR_W-1:0]         memReqAddr
);

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r8_no_accept_during_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  a_r9_memreq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  a_r4_miss_probe_count: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respProbes == WAYS));

  a_r3_hit_probe_range: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> (respProbes != 0 && respProbes <= WAYS));

  a_r10_resp_not_while_ready: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);

endmodule

bind serial_pcache pcache_checker #(
  .ADDR_W (ADDR_W),
  .WAYS   (WAYS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .respValid   (respValid),
  .respHit     (respHit),
  .respProbes  (respProbes),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr)
);

// File: tb/serial_pcache_test.sv
module serial_pcache_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int LINES  = 16;
  localparam int WAYS   = 4;
  localparam int SETS   = LINES / WAYS;
  localparam int CNT_W  = $clog2(WAYS+1);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr;
  logic              respValid;
  logic [DATA_W-1:0] respData;
  logic              respHit;
  logic [CNT_W-1:0]  respProbes;
  logic              memReqValid;
  logic              memReqReady;
  logic [ADDR_W-1:0] memReqAddr;
  logic              memRespValid;
  logic [DATA_W-1:0] memRespData;

  serial_pcache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WAYS(WAYS)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .respValid(respValid), .respData(respData), .respHit(respHit), .respProbes(respProbes),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;
  int memCount = 0;
  int expMemCount = 0;
  logic [ADDR_W-1:0] lastMemAddr = '0;

  always @(posedge clk) cycle <= cycle + 1;

  typedef struct {
    int  addr;
    int  data;
    int  probes;
    bit  hit;
    int  acceptEdge;
    int  memCnt;
  } item_t;
  item_t sb[$];

  // Reference model of placement, built from the requirements
  bit mValid [LINES];
  int mTag   [LINES];
  int mRr    [SETS];

  function automatic int memWord(input int a);
    return (a * 13 + 16'h5a) & 16'hffff;
  endfunction

  function automatic void predict(input int a, output int probes, output bit hit);
    int s, t, line, way;
    s = a % SETS;
    t = a / SETS;
    hit = 0;
    probes = WAYS;
    for (int i = 0; i < WAYS; i++) begin
      line = i * SETS + s;
      if (!hit && mValid[line] && mTag[line] == t) begin
        hit = 1;
        probes = i + 1;
      end
    end
    if (!hit) begin
      way = -1;
      for (int i = WAYS-1; i >= 0; i--) if (!mValid[i * SETS + s]) way = i;
      if (way < 0) begin
        way = mRr[s];
        mRr[s] = (mRr[s] + 1) % WAYS;
      end
      mValid[way * SETS + s] = 1;
      mTag[way * SETS + s] = t;
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: predicts the outcome, pushes it, then issues the request
  task automatic doReq(input int a);
    item_t it;
    int p;
    bit h;
    predict(a, p, h);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    if (!h) expMemCount++;
    it.addr = a; it.data = memWord(a); it.probes = p; it.hit = h;
    it.acceptEdge = cycle + 1; it.memCnt = expMemCount;
    sb.push_back(it);
    reqValid = 1'b1;
    reqAddr  = ADDR_W'(a);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R8", "reqReady after accept", int'(reqReady), 0);
  endtask

  // Monitor: pops expected items as responses appear
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rstN && respValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected response", 1, 0);
        end else begin
          it = sb.pop_front();
          check(respHit == it.hit, it.hit ? "R3" : "R4", "respHit", int'(respHit), int'(it.hit));
          check(int'(respProbes) == it.probes, it.hit ? "R3" : "R7", "respProbes",
                int'(respProbes), it.probes);
          check(int'(respData) == it.data, it.hit ? "R11" : "R4", "respData",
                int'(respData), it.data);
          check(memCount == it.memCnt, it.hit ? "R5" : "R4", "memory request count",
                memCount, it.memCnt);
          if (it.hit)
            check(cycle - it.acceptEdge == it.probes, "R3", "hit latency",
                  cycle - it.acceptEdge, it.probes);
          else
            check(int'(lastMemAddr) == it.addr, "R4", "memReqAddr",
                  int'(lastMemAddr), it.addr);
        end
        @(negedge clk);
        check(respValid == 1'b0, "R10", "respValid pulse width", int'(respValid), 0);
      end
    end
  end

  // Next-level memory model with a varying accept stall
  initial begin
    logic [ADDR_W-1:0] held;
    memReqReady  = 1'b0;
    memRespValid = 1'b0;
    memRespData  = '0;
    forever begin
      @(negedge clk);
      if (rstN && memReqValid) begin
        held = memReqAddr;
        for (int k = 0; k < memCount % 3; k++) begin
          @(negedge clk);
          check(memReqValid && memReqAddr == held, "R9", "request held during stall",
                int'(memReqAddr), int'(held));
        end
        memReqReady = 1'b1;
        lastMemAddr = memReqAddr;
        memCount++;
        @(negedge clk);
        memReqReady = 1'b0;
        @(negedge clk);
        @(negedge clk);
        memRespValid = 1'b1;
        memRespData  = DATA_W'(memWord(int'(lastMemAddr)));
        @(negedge clk);
        memRespValid = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cycle, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic int mk(input int tag, input int set);
    return tag * SETS + set;
  endfunction

  initial begin
    int seed;
    for (int i = 0; i < LINES; i++) begin mValid[i] = 0; mTag[i] = 0; end
    for (int s = 0; s < SETS; s++) mRr[s] = 0;
    rstN = 1'b0;
    reqValid = 1'b0;
    reqAddr = '0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "reqReady in reset", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    check(respValid == 1'b0, "R1", "respValid after reset", int'(respValid), 0);
    check(memReqValid == 1'b0, "R1", "memReqValid after reset", int'(memReqValid), 0);

    // R1 R6: fill set 1 from empty, positions taken in probe order
    doReq(mk(4, 1)); doReq(mk(9, 1)); doReq(mk(14, 1)); doReq(mk(19, 1));
    // R2 R3: hits on probes 1..4
    doReq(mk(4, 1)); doReq(mk(9, 1)); doReq(mk(14, 1)); doReq(mk(19, 1));
    // R2: same tags in set 2 miss, then hit on probe 1
    doReq(mk(4, 2)); doReq(mk(4, 2));
    // R7: full set 1 replaces round-robin positions 0 then 1
    doReq(mk(24, 1)); doReq(mk(4, 1)); doReq(mk(14, 1));
    doReq(mk(24, 1)); doReq(mk(4, 1)); doReq(mk(9, 1));
    // R7: independent pointer for set 2
    doReq(mk(5, 2)); doReq(mk(6, 2)); doReq(mk(7, 2)); doReq(mk(8, 2));
    doReq(mk(5, 2)); doReq(mk(4, 2));
    // Mixed pattern over a pool larger than the array
    seed = 7;
    for (int n = 0; n < 60; n++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      doReq(mk((seed >> 8) % 6, (seed >> 16) % SETS));
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule